// File: doc/BRIEF.md
# Counter Module Control and Status Register Interface

This block is the host-facing register file of a ten-channel counter/timer module. It holds two 16-bit registers. Each can be reached with a byte access or a 16-bit access on a simple address/data bus. The board control register holds three things: a carrier clock-speed select bit, a read-only model identifier and a write-only software reset trigger. The interrupt status register gathers pending interrupts from the counter/timer channels. Each pending bit is released either by writing a one to it or by the channel dropping its interrupt enable.

Byte ordering is big-endian. The odd byte address carries the low-order byte (bits 7:0) and the even byte address carries the high-order byte (bits 15:8). A 16-bit access moves both bytes at once and ignores address bit 0. The bus data is always register-aligned: bits 7:0 of the bus carry the low-order byte and bits 15:8 carry the high-order byte.

Top module: `cnt_regif`

## Requirements
- R1: Address bit 1 selects the register. A value of 0 (byte addresses 0x00/0x01) selects board control and a value of 1 (byte addresses 0x02/0x03) selects interrupt status. A read drives `bus_rdata` only while `bus_sel`=1 and `bus_wr`=0; otherwise `bus_rdata` is 0.
- R2: Lanes are chosen as follows. When `bus_half`=0 and `bus_addr[0]`=1, only bits 7:0 are accessed. When `bus_half`=0 and `bus_addr[0]`=0, only bits 15:8 are accessed. When `bus_half`=1, both lanes are accessed. Lanes that are not accessed read as 0 and are not written.
- R3: Control bit 0 is read/write and drives `clk_fast` (0 = slow carrier, 1 = fast carrier). It is 0 after reset and changes only when the low lane of the control register is written.
- R4: Control bits 10:8 always read 3'b111. Writes to them have no effect.
- R5: Writing 1 to control bit 15 through the high lane raises `soft_rst` for exactly one cycle, in the cycle after the write. Control bits 15, 14:11 and 7:1 always read 0.
- R6: While `soft_rst` is 1, the next clock edge clears control bit 0 and every pending bit, exactly as `rst` does. This overrides any write or event in that cycle.
- R7: Status bit i (i < 10) becomes 1 on the edge after a cycle in which `ch_event[i]`=1 and `ch_irq_en[i]`=1. Status bits 15:10 read 0.
- R8: Writing 1 to status bit i clears it on the next edge. Writing 0 leaves it unchanged. Bits 7:0 are written through the low lane and bits 9:8 through the high lane.
- R9: A cycle with `ch_irq_en[i]`=0 leaves status bit i at 0 after the next edge.
- R10: When an event and a write-one-to-clear hit the same enabled channel in the same cycle, the bit is 1 after the edge.
- R11: `irq` is 1 exactly when at least one status bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Byte address within the block |
| bus_half | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Register-aligned write data |
| bus_rdata | output | 16 | Register-aligned read data, combinational |
| ch_event | input | 10 | Per-channel interrupt event pulses |
| ch_irq_en | input | 10 | Per-channel interrupt enable levels |
| soft_rst | output | 1 | One-cycle software reset pulse |
| clk_fast | output | 1 | Carrier clock-speed select level |
| irq | output | 1 | OR of all pending interrupts |

## Verification
Several rules are checked by assertions on every cycle:
- the one-cycle shape of the software reset pulse and its clearing effect;
- that a disabled channel is never pending;
- event setting, clear, and event-over-clear priority on each channel;
- constant-zero and identifier fields of the read data.

Some behaviour can only be shown by the bench's scenarios, where a reference model tracks the expected state through random traffic: byte-lane routing under big-endian addressing, that a write to one lane leaves the other untouched, and that identifier bits resist writes.

// File: rtl/cnt_regif_pkg.sv
package cnt_regif_pkg;

    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 2;
    localparam int LANE_W   = 8;
    localparam int NUM_CH   = 10;
    localparam int ID_W     = 3;
    localparam int ID_LSB   = 8;
    localparam int CLK_BIT  = 0;
    localparam int SRST_BIT = 15;
    localparam logic [ID_W-1:0] MODEL_ID = 3'b111;

    // register select carried by address bit 1
    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic hi;   // bits 15:8, even byte address
        logic lo;   // bits 7:0, odd byte address
    } lane_t;

    typedef struct packed {
        logic  wr_ctrl;
        logic  wr_stat;
        logic  rd_ctrl;
        logic  rd_stat;
        lane_t lanes;
    } access_t;

    function automatic lane_t lanes_of(input logic addr0, input logic half);
        lane_t l;
        if (half) begin
            l.hi = 1'b1;
            l.lo = 1'b1;
        end else begin
            l.hi = ~addr0;
            l.lo = addr0;
        end
        return l;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input lane_t l);
        return {{LANE_W{l.hi}}, {LANE_W{l.lo}}};
    endfunction

endpackage

// File: rtl/cnt_regif_decode.sv
module cnt_regif_decode
    import cnt_regif_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_half,
    output access_t           acc
);
    reg_sel_e which;

    always_comb begin
        which       = reg_sel_e'(bus_addr[1]);
        acc.lanes   = lanes_of(bus_addr[0], bus_half);
        acc.wr_ctrl = bus_sel &  bus_wr & (which == SEL_CTRL);
        acc.wr_stat = bus_sel &  bus_wr & (which == SEL_STAT);
        acc.rd_ctrl = bus_sel & ~bus_wr & (which == SEL_CTRL);
        acc.rd_stat = bus_sel & ~bus_wr & (which == SEL_STAT);
    end
endmodule

// File: rtl/cnt_regif_ctrl.sv
module cnt_regif_ctrl
    import cnt_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic              wbit_clk,
    input  logic              wbit_srst,
    output logic              clk_fast,
    output logic              soft_rst,
    output logic [DATA_W-1:0] rd_val
);
    logic srst_req;

    assign srst_req = acc.wr_ctrl & acc.lanes.hi & wbit_srst;

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            clk_fast <= 1'b0;
        else if (acc.wr_ctrl && acc.lanes.lo)
            clk_fast <= wbit_clk;
    end

    always_ff @(posedge clk) begin
        if (rst)
            soft_rst <= 1'b0;
        else
            soft_rst <= srst_req & ~soft_rst;
    end

    always_comb begin
        rd_val                 = '0;
        rd_val[CLK_BIT]        = clk_fast;
        rd_val[ID_LSB +: ID_W] = MODEL_ID;
    end

    AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !soft_rst);                                   // R5
    AST_SRST_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (srst_req && !soft_rst) |=> soft_rst);                     // R5
    AST_SRST_CLEARS_CLK: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !clk_fast);                                   // R6
    AST_CLK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!(acc.wr_ctrl && acc.lanes.lo) && !soft_rst) |=> $stable(clk_fast)); // R3
endmodule

// File: rtl/cnt_regif_pend.sv
module cnt_regif_pend #(
    parameter int N_CH = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            soft_rst,
    input  logic [N_CH-1:0] clr,
    input  logic [N_CH-1:0] evt,
    input  logic [N_CH-1:0] en,
    output logic [N_CH-1:0] pend
);
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst || soft_rst)
                pend[g] <= 1'b0;
            else
                pend[g] <= en[g] & (evt[g] | (pend[g] & ~clr[g]));
        end

        AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
            !en[g] |=> !pend[g]);                                  // R9
        AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
            (en[g] && evt[g] && !soft_rst) |=> pend[g]);           // R10
        AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
            (clr[g] && !evt[g]) |=> !pend[g]);                     // R8
    end

    AST_SRST_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (pend == '0));                                // R6
endmodule

// File: rtl/cnt_regif.sv
module cnt_regif
    import cnt_regif_pkg::*;
#(
    parameter int N_CH = NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_half,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   ch_event,
    input  logic [N_CH-1:0]   ch_irq_en,
    output logic              soft_rst,
    output logic              clk_fast,
    output logic              irq
);
    access_t           acc;
    logic [DATA_W-1:0] ctrl_val;
    logic [DATA_W-1:0] stat_val;
    logic [DATA_W-1:0] rd_sel;
    logic [N_CH-1:0]   pend;
    logic [N_CH-1:0]   clr;

    cnt_regif_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_half (bus_half),
        .acc      (acc)
    );

    cnt_regif_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .wbit_clk  (bus_wdata[CLK_BIT]),
        .wbit_srst (bus_wdata[SRST_BIT]),
        .clk_fast  (clk_fast),
        .soft_rst  (soft_rst),
        .rd_val    (ctrl_val)
    );

    // bit i lives in the low lane when i < 8, otherwise in the high lane
    for (genvar i = 0; i < N_CH; i++) begin : g_clr
        if (i < LANE_W) begin : g_lo
            assign clr[i] = acc.wr_stat & acc.lanes.lo & bus_wdata[i];
        end else begin : g_hi
            assign clr[i] = acc.wr_stat & acc.lanes.hi & bus_wdata[i];
        end
    end

    cnt_regif_pend #(.N_CH(N_CH)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .clr      (clr),
        .evt      (ch_event),
        .en       (ch_irq_en),
        .pend     (pend)
    );

    always_comb begin
        stat_val           = '0;
        stat_val[N_CH-1:0] = pend;
        if (acc.rd_ctrl)
            rd_sel = ctrl_val;
        else if (acc.rd_stat)
            rd_sel = stat_val;
        else
            rd_sel = '0;
        bus_rdata = rd_sel & lane_mask(acc.lanes);
    end

    assign irq = |pend;

    AST_CTRL_ZERO_FIELDS: assert property (@(posedge clk) disable iff (rst)
        acc.rd_ctrl |-> (bus_rdata[15:11] == '0 && bus_rdata[7:1] == '0)); // R5
    AST_MODEL_ID: assert property (@(posedge clk) disable iff (rst)
        (acc.rd_ctrl && acc.lanes.hi) |-> (bus_rdata[10:8] == MODEL_ID));  // R4
    AST_STAT_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc.rd_stat |-> (bus_rdata[DATA_W-1:N_CH] == '0));                 // R7
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |-> (bus_rdata == '0));                      // R1
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (stat_val != '0));                                  // R11
endmodule

// File: tb/cnt_regif_tb.sv
module cnt_regif_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_half = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NCH-1:0] ch_event = '0, ch_irq_en = '0;
    logic        soft_rst, clk_fast, irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference state
    logic           m_clk = 1'b0;
    logic           m_srst = 1'b0;
    logic [NCH-1:0] m_pend = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cnt_regif u_dut (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_half(bus_half), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_event(ch_event), .ch_irq_en(ch_irq_en),
        .soft_rst(soft_rst), .clk_fast(clk_fast), .irq(irq)
    );

    function automatic logic [15:0] exp_mask(input logic a0, input logic half);
        if (half) return 16'hFFFF;
        return a0 ? 16'h00FF : 16'hFF00;
    endfunction

    function automatic logic [15:0] exp_read(input logic s, input logic w,
                                             input logic [1:0] a, input logic h);
        logic [15:0] v;
        if (!s || w) return 16'h0000;
        if (a[1] == 1'b0) v = {5'b0, 3'b111, 7'b0, m_clk};
        else              v = {6'b0, m_pend};
        return v & exp_mask(a[0], h);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle: drive at negedge, check outputs, advance model at posedge
    task automatic cycle(input logic s, input logic w, input logic [1:0] a,
                         input logic h, input logic [15:0] d,
                         input logic [NCH-1:0] ev, input logic [NCH-1:0] en,
                         input string tag);
        logic [15:0]    msk;
        logic [NCH-1:0] clr;
        logic           nsrst;
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_half = h; bus_wdata = d;
        ch_event = ev; ch_irq_en = en;
        #1;
        chk({tag, " R1 R2 rdata"}, bus_rdata, exp_read(s, w, a, h));
        chk("R11 irq", {15'b0, irq}, {15'b0, |m_pend});
        chk("R3 clk_fast", {15'b0, clk_fast}, {15'b0, m_clk});
        chk("R5 soft_rst", {15'b0, soft_rst}, {15'b0, m_srst});
        msk = exp_mask(a[0], h);
        clr = (s && w && a[1]) ? (d[NCH-1:0] & msk[NCH-1:0]) : '0;
        nsrst = s && w && !a[1] && msk[15] && d[15] && !m_srst;
        @(posedge clk);
        if (m_srst) begin
            m_clk  = 1'b0;
            m_pend = '0;
        end else begin
            if (s && w && !a[1] && msk[0]) m_clk = d[0];
            m_pend = en & (ev | (m_pend & ~clr));
        end
        m_srst = nsrst;
    endtask

    localparam logic [NCH-1:0] ALL = '1;

    initial begin
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state
        chk("R3 reset clk_fast", {15'b0, clk_fast}, 16'h0);
        chk("R7 reset irq", {15'b0, irq}, 16'h0);
        // read control full, check id and zero bits
        cycle(1,0,2'b00,1,16'h0,0,ALL,"R4 R5 ctrl read");
        // try to write id bits and bit0 via half write
        cycle(1,1,2'b00,1,16'h78FF,0,ALL,"R4 write id");
        cycle(1,0,2'b00,1,16'h0,0,ALL,"R4 R3 readback");
        // byte read at even address gives high byte only
        cycle(1,0,2'b00,0,16'h0,0,ALL,"R2 even byte");
        cycle(1,0,2'b01,0,16'h0,0,ALL,"R2 odd byte");
        // clear bit0 through odd byte write
        cycle(1,1,2'b01,0,16'h0000,0,ALL,"R3 clear");
        // high-lane write of bit0 must not touch it
        cycle(1,1,2'b00,0,16'h0001,0,ALL,"R2 hi lane no bit0");
        cycle(1,0,2'b01,0,16'h0,0,ALL,"R2 check");
        // events set pending
        cycle(0,0,2'b10,0,16'h0,10'h3FF,ALL,"R7 events");
        cycle(1,0,2'b10,1,16'h0,0,ALL,"R7 read status");
        // odd byte clear of bits 7:0, bits 9:8 stay
        cycle(1,1,2'b11,0,16'hFFFF,0,ALL,"R8 clear lo");
        cycle(1,0,2'b10,1,16'h0,0,ALL,"R8 after lo");
        // write zero no effect
        cycle(1,1,2'b10,1,16'h0000,0,ALL,"R8 write zero");
        // even byte clear of bit 9
        cycle(1,1,2'b10,0,16'h0200,0,ALL,"R8 clear hi");
        cycle(1,0,2'b11,0,16'h0,0,ALL,"R8 readback");
        // event vs clear collision
        cycle(1,1,2'b10,1,16'h0104,10'h004,ALL,"R10 collide");
        cycle(1,0,2'b10,1,16'h0,0,ALL,"R10 readback");
        // disable clears
        cycle(0,0,2'b00,0,16'h0,10'h001,~10'h005,"R9 disable");
        cycle(1,0,2'b10,1,16'h0,0,ALL,"R9 readback");
        // soft reset: set clk first, load pending, then trigger
        cycle(1,1,2'b01,0,16'h0001,10'h2AA,ALL,"R6 setup");
        cycle(1,1,2'b00,0,16'h8000,0,ALL,"R5 trigger");
        cycle(1,1,2'b00,0,16'h8000,10'h3FF,ALL,"R6 pulse");
        cycle(1,0,2'b00,1,16'h0,0,ALL,"R6 after");
        cycle(1,0,2'b10,1,16'h0,0,ALL,"R6 status");
        // random traffic
        for (int k = 0; k < 600; k++) begin
            logic [15:0] d;
            logic [NCH-1:0] en;
            d = 16'($urandom);
            if ($urandom_range(7) != 0) d[15] = 1'b0;
            en = ALL;
            for (int c = 0; c < NCH; c++)
                if ($urandom_range(7) == 0) en[c] = 1'b0;
            cycle(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), d,
                  NCH'($urandom) & NCH'($urandom), en, "R2 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule